// File: doc/BRIEF.md
# Panel Configuration Register Slave over SPI

This block holds the byte-wide configuration registers of a small TFT panel controller and exposes them to a host through a four-wire serial port in SPI mode 0. The host opens a transaction by pulling chip select low. It then sends a command byte: the top bit picks the direction (0 write, 1 read) and the lower seven bits carry the register address. A write follows this with one data byte. A read receives one byte back on MISO while the host clocks eight more bits.

The serial pins are oversampled by the system clock through two-stage synchronizers, so the host clock must be well below a quarter of the system clock. Writes are committed only when chip select is released. The decoded fields drive the panel datapath as parallel outputs: power control, scan and input mode, signal polarity, sync mode and the eight gamma nybble pairs. Register 0 holds a fixed identification value. Writing 0 to bit 0 of the global-reset register returns the whole bank to its defaults.

Top module: `panel_cfg_spi`

## Requirements
- R1: Bytes are MSB first and MOSI is sampled on the rising SCLK edge; in the command byte, bit 7 = 1 means read, bit 7 = 0 means write, and bits 6:0 are the register address.
- R2: A write commits on the release of chip select only if exactly 16 SCLK rising edges were seen; a release after any other count leaves every register unchanged.
- R3: In a read, MISO presents the addressed register MSB first during the second byte, valid before each rising edge and updated after falling edges; MISO is 0 while chip select is high.
- R4: Address 0x00 always reads 0x96 and writes to it change nothing.
- R5: Addresses 0x01 to 0x44 are writable; an address above 0x44 reads 0x00 and a write to it changes nothing.
- R6: After reset, 0x01=0x0F, 0x02=0x2E, 0x03=0x12, 0x04=0x01, 0x06=0x0F (bits 1:0 scan direction both set, bits 3:2 = 3 autodetect, bits 7:4 input format 0), 0x07=0x00, 0x0A=0x09 (bits 0 and 3 set, bits 1 and 2 clear), and every other writable address is 0x00.
- R7: A committed write to 0x04 with bit 0 clear restores every writable register, 0x04 included, to its R6 default; with bit 0 set, the value is simply stored.
- R8: pwr_ctrl_o mirrors 0x07 (bit 0 normal/standby, bits 5:1 supply enables, bit 6 auto sequencing), entry_mode_o mirrors 0x06, pol_ctrl_o mirrors 0x0A and sync_ctrl_o mirrors 0x0B, each updated on the clock after the commit.
- R9: For gamma point n (0 to 7) at address 0x10+n, gamma_pos_o[4n+3:4n] is the register's low nybble and gamma_neg_o[4n+3:4n] its high nybble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| pwr_ctrl_o | output | 8 | Power control register |
| entry_mode_o | output | 8 | Scan direction, video standard and input format |
| pol_ctrl_o | output | 8 | Signal polarity register |
| sync_ctrl_o | output | 8 | Sync mode register |
| gamma_pos_o | output | 32 | Positive gamma nybbles, point 0 in the low bits |
| gamma_neg_o | output | 32 | Negative gamma nybbles, point 0 in the low bits |

## Verification
A write to the global-reset register both stores its data byte and, when bit 0 is clear, triggers the bank-wide restore on the same commit clock. The two actions therefore compete for register 0x04 and for every other register. The bench first loads non-default values into power, polarity and entry mode. It then writes 0x00 to address 0x04 and checks that the outputs are back at their defaults and that 0x04 reads back 0x01 rather than the 0x00 just written. A write of a value with bit 0 set to the same address is checked separately to show it is stored.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned LAST_ADDR = 'h44;
  localparam int unsigned NUM_REGS  = LAST_ADDR + 1;
  localparam int unsigned NUM_GAMMA = 8;

  localparam logic [DATA_W-1:0] ID_VALUE = 8'h96;

  localparam logic [ADDR_W-1:0] A_ID     = 7'h00;
  localparam logic [ADDR_W-1:0] A_GRST   = 7'h04;
  localparam logic [ADDR_W-1:0] A_ENTRY  = 7'h06;
  localparam logic [ADDR_W-1:0] A_PWR    = 7'h07;
  localparam logic [ADDR_W-1:0] A_POL    = 7'h0A;
  localparam logic [ADDR_W-1:0] A_SYNC   = 7'h0B;
  localparam logic [ADDR_W-1:0] A_GAMMA0 = 7'h10;

  function automatic logic [DATA_W-1:0] reg_default(input int unsigned a);
    case (a)
      'h01:    return 8'h0F;
      'h02:    return 8'h2E;
      'h03:    return 8'h12;
      'h04:    return 8'h01;
      'h06:    return 8'h0F;
      'h0A:    return 8'h09;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/panel_cfg_sync.sv
module panel_cfg_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/panel_cfg_frame.sv
module panel_cfg_frame
  import panel_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W   = 5;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  localparam int unsigned WR_BITS = 2 * DATA_W;

  logic sclk_s, csn_s, mosi_s;
  logic sclk_q, active_q;
  logic active;
  logic sclk_rise, sclk_fall, cs_release;

  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] tx_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_next;
  logic              rd_load, rd_phase;

  panel_cfg_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  panel_cfg_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync_csn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(csn_i), .q_o(csn_s));
  panel_cfg_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_sync_mosi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mosi_i), .q_o(mosi_s));

  assign active     = ~csn_s;
  assign sclk_rise  = active & sclk_s & ~sclk_q;
  assign sclk_fall  = active & ~sclk_s & sclk_q;
  assign cs_release = active_q & ~active;
  assign rx_next    = {rx_sr[DATA_W-2:0], mosi_s};

  // command byte completes on the 8th rising edge
  assign rd_load   = sclk_rise && (bit_cnt == CNT_W'(DATA_W - 1)) && rx_sr[DATA_W-2];
  assign rd_addr_o = rx_next[ADDR_W-1:0];
  assign rd_phase  = active && cmd_q[DATA_W-1] && (bit_cnt >= CNT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      active_q <= active;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      bit_cnt <= '0;
    end else if (!active) begin
      rx_sr   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      rx_sr <= rx_next;
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(DATA_W - 1))  cmd_q  <= rx_next;
      if (bit_cnt == CNT_W'(WR_BITS - 1)) data_q <= rx_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr <= '0;
    end else if (!active) begin
      tx_sr <= '0;
    end else if (rd_load) begin
      tx_sr <= rd_data_i;
    end else if (sclk_fall && rd_phase && (bit_cnt > CNT_W'(DATA_W))) begin
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o    = rd_phase ? tx_sr[DATA_W-1] : 1'b0;
  assign wr_en_o   = cs_release && !cmd_q[DATA_W-1] && (bit_cnt == CNT_W'(WR_BITS));
  assign wr_addr_o = cmd_q[ADDR_W-1:0];
  assign wr_data_o = data_q;

  a_r3_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s && !active_q) |-> !miso_o);

  a_r2_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  a_r2_commit_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (active_q && csn_s));
endmodule

// File: rtl/panel_cfg_regbank.sv
module panel_cfg_regbank
  import panel_cfg_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic [DATA_W-1:0]             pwr_o,
  output logic [DATA_W-1:0]             entry_o,
  output logic [DATA_W-1:0]             pol_o,
  output logic [DATA_W-1:0]             sync_o,
  output logic [4*NUM_GAMMA-1:0]        gamma_pos_o,
  output logic [4*NUM_GAMMA-1:0]        gamma_neg_o
);
  logic [DATA_W-1:0] bank [NUM_REGS];
  logic              grst;

  assign grst = wr_en_i && (wr_addr_i == A_GRST) && !wr_data_i[0];

  assign bank[0] = ID_VALUE;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      bank[i] <= reg_default(i);
      else if (grst)                                    bank[i] <= reg_default(i);
      else if (wr_en_i && (wr_addr_i == ADDR_W'(i)))   bank[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_addr_i == ADDR_W'(k)) rd_data_o = bank[k];
    end
  end

  assign pwr_o   = bank[A_PWR];
  assign entry_o = bank[A_ENTRY];
  assign pol_o   = bank[A_POL];
  assign sync_o  = bank[A_SYNC];

  for (genvar g = 0; g < NUM_GAMMA; g++) begin : g_gamma
    assign gamma_pos_o[4*g +: 4] = bank[int'(A_GAMMA0) + g][3:0];
    assign gamma_neg_o[4*g +: 4] = bank[int'(A_GAMMA0) + g][7:4];
  end

  a_r7_grst_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grst |=> (pwr_o == 8'h00) && (pol_o == 8'h09) && (entry_o == 8'h0F) && (gamma_pos_o == '0));

  a_r4_id_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_ID) |=>
      ($stable(pwr_o) && $stable(pol_o) && $stable(entry_o) && $stable(sync_o) && $stable(gamma_neg_o)));

  a_r5_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > ADDR_W'(LAST_ADDR)) |=>
      ($stable(pwr_o) && $stable(pol_o) && $stable(entry_o) && $stable(sync_o) && $stable(gamma_pos_o)));

  a_r8_pwr_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_PWR) |=> (pwr_o == $past(wr_data_i)));
endmodule

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi
  import panel_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic [7:0]  pwr_ctrl_o,
  output logic [7:0]  entry_mode_o,
  output logic [7:0]  pol_ctrl_o,
  output logic [7:0]  sync_ctrl_o,
  output logic [31:0] gamma_pos_o,
  output logic [31:0] gamma_neg_o
);
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  panel_cfg_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .csn_i     (csn_i),
    .mosi_i    (mosi_i),
    .miso_o    (miso_o),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  panel_cfg_regbank u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .pwr_o       (pwr_ctrl_o),
    .entry_o     (entry_mode_o),
    .pol_o       (pol_ctrl_o),
    .sync_o      (sync_ctrl_o),
    .gamma_pos_o (gamma_pos_o),
    .gamma_neg_o (gamma_neg_o)
  );
endmodule

// File: tb/panel_cfg_spi_tb_top.sv
module panel_cfg_spi_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0]  pwr, entry, pol, syncm;
  logic [31:0] gpos, gneg;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  panel_cfg_spi dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .pwr_ctrl_o(pwr), .entry_mode_o(entry), .pol_ctrl_o(pol),
    .sync_ctrl_o(syncm), .gamma_pos_o(gpos), .gamma_neg_o(gneg));

  // {read, addr, data, expected}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h00, 8'h96}, {1'b1, 8'h01, 8'h00, 8'h0F},
    {1'b1, 8'h02, 8'h00, 8'h2E}, {1'b1, 8'h03, 8'h00, 8'h12},
    {1'b1, 8'h04, 8'h00, 8'h01}, {1'b1, 8'h06, 8'h00, 8'h0F},
    {1'b1, 8'h07, 8'h00, 8'h00}, {1'b1, 8'h0A, 8'h00, 8'h09},
    {1'b0, 8'h07, 8'h7F, 8'h00}, {1'b1, 8'h07, 8'h00, 8'h7F},
    {1'b0, 8'h10, 8'hA7, 8'h00}, {1'b1, 8'h10, 8'h00, 8'hA7},
    {1'b0, 8'h17, 8'h62, 8'h00}, {1'b1, 8'h17, 8'h00, 8'h62},
    {1'b0, 8'h44, 8'h5A, 8'h00}, {1'b1, 8'h44, 8'h00, 8'h5A},
    {1'b0, 8'h45, 8'h33, 8'h00}, {1'b1, 8'h45, 8'h00, 8'h00},
    {1'b0, 8'h00, 8'h12, 8'h00}, {1'b1, 8'h00, 8'h00, 8'h96},
    {1'b0, 8'h0A, 8'h76, 8'h00}, {1'b1, 8'h0A, 8'h00, 8'h76},
    {1'b0, 8'h06, 8'hB0, 8'h00}, {1'b1, 8'h06, 8'h00, 8'hB0},
    {1'b0, 8'h0B, 8'h0C, 8'h00}, {1'b1, 8'h0B, 8'h00, 8'h0C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                      output logic [7:0] rx);
    logic [15:0] tx;
    tx = {b0, b1};
    rx = '0;
    @(negedge clk);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      wait_clk(HALF);
      if (i >= 8 && i < 16) rx[15-i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer({1'b0, a[6:0]}, d, 16, dummy);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    xfer({1'b1, a[6:0]}, 8'h00, 16, d);
  endtask

  initial begin
    logic [7:0] r;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R6 reset state at outputs, R3 idle MISO
    chk("R6 pwr reset", pwr, 8'h00);
    chk("R6 pol reset", pol, 8'h09);
    chk("R6 entry reset", entry, 8'h0F);
    chk("R9 gamma reset", {gpos, gneg}, 64'h0);
    chk("R3 miso idle", miso, 1'b0);

    // R1 R3 R4 R5 R6 table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][24]) begin
        rd(VEC[v][23:16], r);
        chk($sformatf("R1/R3 read addr %h (R4 R5 R6)", VEC[v][23:16]), r, VEC[v][7:0]);
      end else begin
        wr(VEC[v][23:16], VEC[v][15:8]);
      end
    end

    // R8 output mirrors
    chk("R8 pwr_ctrl_o", pwr, 8'h7F);
    chk("R8 entry_mode_o", entry, 8'hB0);
    chk("R8 pol_ctrl_o", pol, 8'h76);
    chk("R8 sync_ctrl_o", syncm, 8'h0C);
    // R9 gamma packing: point 0 = A7, point 7 = 62
    chk("R9 gamma pos", gpos, 32'h2000_0007);
    chk("R9 gamma neg", gneg, 32'h6000_000A);

    // R2 short transaction aborts
    xfer(8'h07, 8'h11, 12, r);
    chk("R2 abort short", pwr, 8'h7F);
    // R2 overlong transaction ignored
    xfer(8'h07, 8'h22, 24, r);
    chk("R2 abort long", pwr, 8'h7F);
    rd(8'h07, r);
    chk("R2 readback after aborts", r, 8'h7F);

    // R7 bit0 set only stores
    wr(8'h04, 8'h03);
    rd(8'h04, r);
    chk("R7 store bit0 set", r, 8'h03);
    chk("R7 no restore bit0 set", pol, 8'h76);

    // R7 global restore
    wr(8'h04, 8'h00);
    chk("R7 restore pwr", pwr, 8'h00);
    chk("R7 restore pol", pol, 8'h09);
    chk("R7 restore entry", entry, 8'h0F);
    chk("R7 restore sync", syncm, 8'h00);
    chk("R7 restore gamma", {gpos, gneg}, 64'h0);
    rd(8'h04, r);
    chk("R7 grst reg default", r, 8'h01);
    rd(8'h44, r);
    chk("R7 restore top addr", r, 8'h00);
    rd(8'h00, r);
    chk("R4 id after restore", r, 8'h96);
    chk("R3 miso idle end", miso, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule